// File: doc/BRIEF.md
# Timer Channel Transition Capture Unit

This block is the input-event side of one timer channel. A pin is synchronized and compared with its previous level. Two independently programmed edge qualifiers turn the result into a first-transition event and a second-transition event. Two transition latches and two match latches record what has happened. Two capture registers each take a snapshot of one of two free-running time bases at the moment a latch is asserted. The snapshot is a copy of the count present in the cycle of the event.

A channel mode decides three things: whether the second transition latch waits for the first, which latch raises the one-cycle service request, and whether the first transition keeps recapturing. A match-enable latch guards match recognition. Writing a new match value arms it, and that write wins over the disarm caused by a match recognised in the same cycle. Every pin of the block is a plain control or status signal. No data stream crosses its boundary, so it has no valid/ready handshake and no back-pressure.

Top module: `tcap_channel`

## Requirements
- R1: After reset all four latches, the match-enable latch, both capture registers and the service request are zero.
- R2: Each edge select uses 00 = no edge, 01 = rising, 10 = falling, 11 = either. The pin goes through two synchronizer flops. A transition latch is therefore visible three rising clock edges after the pin changes and not after two.
- R3: The capture select bit for each register picks time base A when 0 and time base B when 1.
- R4: A capture loads the time-base value present in the cycle in which the latch assertion condition holds. It still loads when a latch clear arrives in that same cycle, and the latch then stays clear.
- R5: In modes 00 and 01 the second transition latch sets only if the first transition latch was already set in an earlier cycle.
- R6: In mode 00 (single transition) the first transition latch raises the service request. The second latch may still set on a later edge and load capture register 2, but raises no request. The request lasts one cycle.
- R7: In mode 01 (double transition) only the assertion of the second transition latch raises the service request.
- R8: In modes 10 and 11 (user defined) the second transition latch sets without regard to the first, and the assertion of either transition latch raises the service request.
- R9: With continuous capture enabled and the first transition latch set, every further first-edge event reloads capture register 1 and leaves capture register 2 unchanged. With continuous capture disabled there is no reload.
- R10: A capture register loaded by a transition is not overwritten by a later match capture until the synchronous clear.
- R11: A match pulse sets its match latch, and captures, only while the match-enable latch is set. Recognition clears the enable. A match write sets it, with priority over that clear.
- R12: The synchronous clear resets all four latches and removes transition-capture protection. It does not touch the match-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous channel input pin |
| tb_a_i | input | TB_W | Time base A |
| tb_b_i | input | TB_W | Time base B |
| match1_i | input | 1 | Match pulse for register 1 |
| match2_i | input | 1 | Match pulse for register 2 |
| match_wr_i | input | 1 | New match value written; arms the match enable |
| edge1_sel_i | input | 2 | First transition edge select |
| edge2_sel_i | input | 2 | Second transition edge select |
| cap1_sel_i | input | 1 | Time-base select for capture register 1 |
| cap2_sel_i | input | 1 | Time-base select for capture register 2 |
| mode_i | input | 2 | Channel mode (00 single, 01 double, 1x user) |
| ccap_en_i | input | 1 | Continuous capture enable |
| clr_i | input | 1 | Synchronous clear of the four latches |
| cap1_o | output | TB_W | Capture register 1 |
| cap2_o | output | TB_W | Capture register 2 |
| tdl1_o | output | 1 | First transition latch |
| tdl2_o | output | 1 | Second transition latch |
| mrl1_o | output | 1 | Match latch 1 |
| mrl2_o | output | 1 | Match latch 2 |
| mre_o | output | 1 | Match-enable latch |
| srq_o | output | 1 | Service request pulse |

## Verification
Two collisions are provoked on purpose. In the first, a latch clear and a latch assertion land in the same cycle: the bench raises the match pulse and the clear together, then expects the latch to read zero and the capture register to hold the time base of that cycle. In the second, a match write and a match recognition coincide: the bench expects the enable to stay set while the match latch rises. A third case is a match capture that arrives after a transition capture; the register must keep the transition value until the clear.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_DOUBLE   = 2'b01,
    MODE_USER     = 2'b10,
    MODE_USER_ALT = 2'b11
  } chan_mode_e;

  localparam int unsigned NUM_CAP = 2;

  function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

endpackage

// File: rtl/tcap_edge_detect.sv
module tcap_edge_detect
  import tcap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel1_i,
  input  logic [1:0] sel2_i,
  output logic       ev1_o,
  output logic       ev2_o
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;
  logic                   rise;
  logic                   fall;

  // synchronizer chain, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign level = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  assign ev1_o = edge_hit(edge_sel_e'(sel1_i), rise, fall);
  assign ev2_o = edge_hit(edge_sel_e'(sel2_i), rise, fall);

  // a detected rising edge means the delayed level was low one cycle earlier
  assert_rise_history_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && $past(rst_n)) |-> !$past(level));

endmodule

// File: rtl/tcap_latches.sv
module tcap_latches
  import tcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev1_i,
  input  logic       ev2_i,
  input  logic       match1_i,
  input  logic       match2_i,
  input  logic       match_wr_i,
  input  logic       clr_i,
  input  logic [1:0] mode_i,
  output logic       tdl1_o,
  output logic       tdl2_o,
  output logic       mrl1_o,
  output logic       mrl2_o,
  output logic       mre_o,
  output logic       tdl1_set_o,
  output logic       tdl2_set_o,
  output logic       mrl1_set_o,
  output logic       mrl2_set_o,
  output logic       srq_o
);

  chan_mode_e mode;
  logic       user_mode;
  logic       tdl1_q, tdl2_q, mrl1_q, mrl2_q, mre_q, srq_q;
  logic       tdl1_set, tdl2_set, mrl1_set, mrl2_set;
  logic       srq_d;

  assign mode      = chan_mode_e'(mode_i);
  assign user_mode = (mode == MODE_USER) || (mode == MODE_USER_ALT);

  // assertion conditions; each still counts when a clear arrives together
  assign tdl1_set = ev1_i & ~tdl1_q;
  assign tdl2_set = ev2_i & ~tdl2_q & (user_mode | tdl1_q);
  assign mrl1_set = match1_i & mre_q & ~mrl1_q;
  assign mrl2_set = match2_i & mre_q & ~mrl2_q;

  always_comb begin
    unique case (mode)
      MODE_SINGLE: srq_d = tdl1_set;
      MODE_DOUBLE: srq_d = tdl2_set;
      default:     srq_d = tdl1_set | tdl2_set;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdl1_q <= 1'b0;
      tdl2_q <= 1'b0;
      mrl1_q <= 1'b0;
      mrl2_q <= 1'b0;
      mre_q  <= 1'b0;
      srq_q  <= 1'b0;
    end else begin
      tdl1_q <= clr_i ? 1'b0 : (tdl1_q | tdl1_set);
      tdl2_q <= clr_i ? 1'b0 : (tdl2_q | tdl2_set);
      mrl1_q <= clr_i ? 1'b0 : (mrl1_q | mrl1_set);
      mrl2_q <= clr_i ? 1'b0 : (mrl2_q | mrl2_set);
      // a match write wins over the disarm from recognition
      if (match_wr_i)                mre_q <= 1'b1;
      else if (mrl1_set || mrl2_set) mre_q <= 1'b0;
      srq_q  <= srq_d;
    end
  end

  assign tdl1_o     = tdl1_q;
  assign tdl2_o     = tdl2_q;
  assign mrl1_o     = mrl1_q;
  assign mrl2_o     = mrl2_q;
  assign mre_o      = mre_q;
  assign srq_o      = srq_q;
  assign tdl1_set_o = tdl1_set;
  assign tdl2_set_o = tdl2_set;
  assign mrl1_set_o = mrl1_set;
  assign mrl2_set_o = mrl2_set;

  assert_ordered_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tdl2_q) && !$past(mode_i[1])) |-> $past(tdl1_q));

  assert_clear_latches_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!tdl1_q && !tdl2_q && !mrl1_q && !mrl2_q));

  assert_write_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    match_wr_i |=> mre_q);

  assert_match_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mrl1_q) || $rose(mrl2_q)) |-> $past(mre_q));

endmodule

// File: rtl/tcap_capture.sv
module tcap_capture #(
  parameter int unsigned TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tb_a_i,
  input  logic [TB_W-1:0] tb_b_i,
  input  logic            sel_i,
  input  logic            tr_load_i,
  input  logic            match_load_i,
  input  logic            clr_i,
  output logic [TB_W-1:0] cap_o
);

  logic [TB_W-1:0] cap_q;
  logic [TB_W-1:0] tb_sel;
  logic            prot_q;
  logic            load;

  assign tb_sel = sel_i ? tb_b_i : tb_a_i;
  // a transition-made capture blocks later match-made ones
  assign load   = tr_load_i | (match_load_i & ~prot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      prot_q <= 1'b0;
    end else begin
      if (load) cap_q <= tb_sel;
      if (clr_i)          prot_q <= 1'b0;
      else if (tr_load_i) prot_q <= 1'b1;
    end
  end

  assign cap_o = cap_q;

  assert_protected_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && !tr_load_i) |=> $stable(cap_q));

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int unsigned TB_W        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_i,
  input  logic [TB_W-1:0] tb_a_i,
  input  logic [TB_W-1:0] tb_b_i,
  input  logic            match1_i,
  input  logic            match2_i,
  input  logic            match_wr_i,
  input  logic [1:0]      edge1_sel_i,
  input  logic [1:0]      edge2_sel_i,
  input  logic            cap1_sel_i,
  input  logic            cap2_sel_i,
  input  logic [1:0]      mode_i,
  input  logic            ccap_en_i,
  input  logic            clr_i,
  output logic [TB_W-1:0] cap1_o,
  output logic [TB_W-1:0] cap2_o,
  output logic            tdl1_o,
  output logic            tdl2_o,
  output logic            mrl1_o,
  output logic            mrl2_o,
  output logic            mre_o,
  output logic            srq_o
);

  logic ev1, ev2;
  logic tdl1, tdl2;
  logic tdl1_set, tdl2_set, mrl1_set, mrl2_set;

  logic [NUM_CAP-1:0] tr_load;
  logic [NUM_CAP-1:0] m_load;
  logic [NUM_CAP-1:0] cap_sel;
  logic [TB_W-1:0]    cap [NUM_CAP];

  tcap_edge_detect #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .sel1_i (edge1_sel_i),
    .sel2_i (edge2_sel_i),
    .ev1_o  (ev1),
    .ev2_o  (ev2)
  );

  tcap_latches u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev1_i      (ev1),
    .ev2_i      (ev2),
    .match1_i   (match1_i),
    .match2_i   (match2_i),
    .match_wr_i (match_wr_i),
    .clr_i      (clr_i),
    .mode_i     (mode_i),
    .tdl1_o     (tdl1),
    .tdl2_o     (tdl2),
    .mrl1_o     (mrl1_o),
    .mrl2_o     (mrl2_o),
    .mre_o      (mre_o),
    .tdl1_set_o (tdl1_set),
    .tdl2_set_o (tdl2_set),
    .mrl1_set_o (mrl1_set),
    .mrl2_set_o (mrl2_set),
    .srq_o      (srq_o)
  );

  // slot 0 also recaptures on first-edge events while continuous capture runs
  assign tr_load[0] = tdl1_set | (ccap_en_i & tdl1 & ev1);
  assign tr_load[1] = tdl2_set;
  assign m_load[0]  = mrl1_set;
  assign m_load[1]  = mrl2_set;
  assign cap_sel[0] = cap1_sel_i;
  assign cap_sel[1] = cap2_sel_i;

  for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
    tcap_capture #(
      .TB_W (TB_W)
    ) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .tb_a_i       (tb_a_i),
      .tb_b_i       (tb_b_i),
      .sel_i        (cap_sel[g]),
      .tr_load_i    (tr_load[g]),
      .match_load_i (m_load[g]),
      .clr_i        (clr_i),
      .cap_o        (cap[g])
    );
  end

  assign cap1_o = cap[0];
  assign cap2_o = cap[1];
  assign tdl1_o = tdl1;
  assign tdl2_o = tdl2;

  assert_reg2_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tdl2_set && !mrl2_set) |=> $stable(cap2_o));

endmodule

// File: tb/tb_tcap_channel.sv
module tb_tcap_channel;

  localparam int  TB_W   = 16;
  localparam time CLK_PD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pin_i = 1'b0;
  logic [TB_W-1:0] tb_a_i = '0;
  logic [TB_W-1:0] tb_b_i = '0;
  logic            match1_i = 1'b0, match2_i = 1'b0, match_wr_i = 1'b0;
  logic [1:0]      edge1_sel_i = 2'b00, edge2_sel_i = 2'b00;
  logic            cap1_sel_i = 1'b0, cap2_sel_i = 1'b0;
  logic [1:0]      mode_i = 2'b00;
  logic            ccap_en_i = 1'b0, clr_i = 1'b0;
  logic [TB_W-1:0] cap1_o, cap2_o;
  logic            tdl1_o, tdl2_o, mrl1_o, mrl2_o, mre_o, srq_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #(CLK_PD/2) clk = ~clk;

  tcap_channel #(.TB_W(TB_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tb_a_i(tb_a_i), .tb_b_i(tb_b_i),
    .match1_i(match1_i), .match2_i(match2_i), .match_wr_i(match_wr_i),
    .edge1_sel_i(edge1_sel_i), .edge2_sel_i(edge2_sel_i),
    .cap1_sel_i(cap1_sel_i), .cap2_sel_i(cap2_sel_i), .mode_i(mode_i),
    .ccap_en_i(ccap_en_i), .clr_i(clr_i),
    .cap1_o(cap1_o), .cap2_o(cap2_o), .tdl1_o(tdl1_o), .tdl2_o(tdl2_o),
    .mrl1_o(mrl1_o), .mrl2_o(mrl2_o), .mre_o(mre_o), .srq_o(srq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // change the pin and wait until the latch update is visible
  task automatic move_pin(input logic v);
    @(negedge clk) pin_i = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle strobe of match/write/clear, tb_a moves on right after the edge
  task automatic strobe(input logic m1, input logic m2, input logic wr, input logic c,
                        input logic [TB_W-1:0] a);
    @(negedge clk);
    match1_i = m1; match2_i = m2; match_wr_i = wr; clr_i = c; tb_a_i = a;
    @(posedge clk);
    @(negedge clk);
    match1_i = 0; match2_i = 0; match_wr_i = 0; clr_i = 0; tb_a_i = a + 1'b1;
  endtask

  task automatic t_reset;
    check("R1 tdl1", tdl1_o, 0); check("R1 tdl2", tdl2_o, 0);
    check("R1 mrl1", mrl1_o, 0); check("R1 mrl2", mrl2_o, 0);
    check("R1 mre", mre_o, 0);   check("R1 srq", srq_o, 0);
    check("R1 cap1", cap1_o, 0); check("R1 cap2", cap2_o, 0);
  endtask

  task automatic t_edges;
    mode_i = 2'b00; edge1_sel_i = 2'b01; edge2_sel_i = 2'b00;
    cap1_sel_i = 0; tb_a_i = 100; tb_b_i = 200;
    @(negedge clk) pin_i = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 not yet after two edges", tdl1_o, 0);
    @(posedge clk); @(negedge clk);
    check("R2 rising sets tdl1", tdl1_o, 1);
    check("R6 single srq", srq_o, 1);
    check("R3 sel0 picks A", cap1_o, 100);
    @(negedge clk);
    check("R6 srq one cycle", srq_o, 0);
    strobe(0, 0, 0, 1, 100);
    move_pin(0);
    check("R2 rising ignores fall", tdl1_o, 0);
    edge1_sel_i = 2'b00;
    move_pin(1);
    check("R2 none ignores rise", tdl1_o, 0);
    edge1_sel_i = 2'b10; cap1_sel_i = 1; tb_b_i = 201;
    move_pin(0);
    check("R2 falling sets tdl1", tdl1_o, 1);
    check("R3 sel1 picks B", cap1_o, 201);
    edge2_sel_i = 2'b11; cap2_sel_i = 0; tb_a_i = 120;
    move_pin(1);
    check("R6 tdl2 sets in single", tdl2_o, 1);
    check("R6 tdl2 no srq", srq_o, 0);
    check("R6 cap2 loads", cap2_o, 120);
  endtask

  task automatic t_double;
    strobe(0, 0, 0, 1, 0);
    mode_i = 2'b01; edge1_sel_i = 2'b01; edge2_sel_i = 2'b11;
    move_pin(0);
    check("R5 tdl2 gated", tdl2_o, 0);
    check("R5 tdl1 idle", tdl1_o, 0);
    move_pin(1);
    check("R7 tdl1 set", tdl1_o, 1);
    check("R7 tdl1 no srq", srq_o, 0);
    cap2_sel_i = 0; tb_a_i = 130;
    move_pin(0);
    check("R5 tdl2 after tdl1", tdl2_o, 1);
    check("R7 tdl2 srq", srq_o, 1);
    check("R7 cap2", cap2_o, 130);
  endtask

  task automatic t_user;
    strobe(0, 0, 0, 1, 0);
    mode_i = 2'b10; edge1_sel_i = 2'b00; edge2_sel_i = 2'b11;
    move_pin(1);
    check("R8 tdl2 ungated", tdl2_o, 1);
    check("R8 tdl1 clear", tdl1_o, 0);
    check("R8 srq from tdl2", srq_o, 1);
    edge1_sel_i = 2'b10;
    move_pin(0);
    check("R8 tdl1 set", tdl1_o, 1);
    check("R8 srq from tdl1", srq_o, 1);
  endtask

  task automatic t_ccap;
    logic [TB_W-1:0] c2;
    strobe(0, 0, 0, 1, 0);
    mode_i = 2'b00; edge1_sel_i = 2'b11; edge2_sel_i = 2'b00;
    ccap_en_i = 1; cap1_sel_i = 0; tb_a_i = 10;
    move_pin(1);
    check("R9 first capture", cap1_o, 10);
    c2 = cap2_o;
    tb_a_i = 11;
    move_pin(0);
    check("R9 recapture", cap1_o, 11);
    check("R9 no second srq", srq_o, 0);
    check("R9 cap2 untouched", cap2_o, c2);
    ccap_en_i = 0; tb_a_i = 12;
    move_pin(1);
    check("R9 disabled no reload", cap1_o, 11);
  endtask

  task automatic t_match;
    strobe(0, 0, 0, 1, 0);
    cap1_sel_i = 0;
    strobe(0, 0, 1, 0, 0);
    check("R11 write arms", mre_o, 1);
    strobe(1, 0, 0, 0, 50);
    check("R11 mrl1 set", mrl1_o, 1);
    check("R4 match capture value", cap1_o, 50);
    check("R11 recognition disarms", mre_o, 0);
    strobe(0, 1, 0, 0, 55);
    check("R11 disarmed ignores match", mrl2_o, 0);
    strobe(0, 0, 1, 0, 0);
    cap2_sel_i = 1; tb_b_i = 77;
    strobe(0, 1, 1, 0, 60);
    check("R11 mrl2 set", mrl2_o, 1);
    check("R11 write wins", mre_o, 1);
    check("R3 cap2 from B", cap2_o, 77);
    strobe(0, 0, 0, 1, 0);
    check("R12 mre kept by clear", mre_o, 1);
    strobe(1, 0, 0, 1, 90);
    check("R4 clear wins latch", mrl1_o, 0);
    check("R4 capture despite clear", cap1_o, 90);
  endtask

  task automatic t_protect;
    strobe(0, 0, 0, 1, 0);
    mode_i = 2'b00; ccap_en_i = 0; edge1_sel_i = 2'b00; edge2_sel_i = 2'b00;
    cap1_sel_i = 0;
    move_pin(0);
    edge1_sel_i = 2'b01; tb_a_i = 300;
    move_pin(1);
    check("R10 transition capture", cap1_o, 300);
    strobe(0, 0, 1, 0, 0);
    strobe(1, 0, 0, 0, 400);
    check("R10 mrl1 set", mrl1_o, 1);
    check("R10 protected", cap1_o, 300);
    strobe(0, 0, 0, 1, 0);
    check("R12 tdl1", tdl1_o, 0); check("R12 tdl2", tdl2_o, 0);
    check("R12 mrl1", mrl1_o, 0); check("R12 mrl2", mrl2_o, 0);
    strobe(0, 0, 1, 0, 0);
    strobe(1, 0, 0, 0, 500);
    check("R12 protection removed", cap1_o, 500);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    t_reset();
    t_edges();
    t_double();
    t_user();
    t_ccap();
    t_match();
    t_protect();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule